// File: doc/BRIEF.md
# Word Reorder and Extend Unit

This block rearranges the bits and bytes of a 32-bit word in a single combinational step, for use beside an integer datapath where results must be ready in the same cycle as their operands. A 3-bit operation code picks one of eight transforms. Four of them only reorder: a full bit mirror, a reversal of all four bytes, a byte swap inside each halfword, and a byte swap of the low halfword whose result is then sign-extended.

The other four first rotate the input right by a whole number of bytes, then widen the low byte or low halfword to 32 bits, either by sign extension or by zero extension. A 2-bit rotate selector gives the byte count. The reorder transforms do not use the rotate selector.

There is no clock, no reset and no state. The output follows the inputs after the logic delay.

Top module: `reorder_ext_unit`

## Requirements
- R1: Operation code 0 mirrors the word: output bit i equals input bit 31-i. Input 0x12345678 gives 0x1E6A2C48.
- R2: Operation code 1 reverses the byte order of the whole word: output bits 7:0 take input bits 31:24, 15:8 take 23:16, 23:16 take 15:8, and 31:24 take 7:0. Input 0x12345678 gives 0x78563412.
- R3: Operation code 2 swaps the two bytes inside each 16-bit half, each half on its own. Input 0x12345678 gives 0x34127856.
- R4: Operation code 3 places input bits 7:0 in output bits 15:8 and input bits 15:8 in output bits 7:0, and fills output bits 31:16 with copies of input bit 7. Input 0x33448899 gives 0xFFFF9988.
- R5: For operation codes 4 to 7, the input is first rotated right by 8 x rot_sel bits (rot_sel from 0 to 3), and the extension is applied to the rotated word. Input 0x55AA8765 with rot_sel 1 and code 4 gives 0xFFFFFF87; with rot_sel 2 and code 5 it gives 0x000055AA; with rot_sel 3 and code 7 it gives 0x00006555.
- R6: Operation code 4 sign-extends bits 7:0 of the rotated word to 32 bits. Input 0x55AA8765 with rot_sel 0 gives 0x00000065.
- R7: Operation code 5 sign-extends bits 15:0 of the rotated word to 32 bits. Input 0x55AA8765 with rot_sel 0 gives 0xFFFF8765.
- R8: Operation code 6 zero-extends bits 7:0 of the rotated word to 32 bits. Input 0x55AA8765 with rot_sel 0 gives 0x00000065.
- R9: Operation code 7 zero-extends bits 15:0 of the rotated word to 32 bits. Input 0x55AA8765 with rot_sel 0 gives 0x00008765.
- R10: For operation codes 0 to 3, the value of rot_sel has no effect on the output.
- R11: The output depends only on the present inputs. An all-zero input gives an all-zero output under every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Source word |
| op_sel | input | 3 | Operation code, 0 to 7, as listed in the requirements |
| rot_sel | input | 2 | Right rotation applied before extension, in bytes |
| data_out | output | 32 | Transformed word |

## Verification
The bound checks are immediate and look at ports only. They take for granted that all three inputs carry known values, and they evaluate nothing while any input bit is unknown. The stimulus keeps to this by driving every input to a defined value from time zero and by using the full range of each input: all eight operation codes and all four rotate values, over directed words and seeded random words. Because every code and every rotate value is legal, the stimulus never needs to steer around an illegal combination.

// File: rtl/reo_pkg.sv
// Package: shared operation encoding and width constants for the reorder/extend unit.
// Assumes the datapath is built from 8-bit bytes and 16-bit halfwords.
package reo_pkg;

    // Width of a byte lane and of a halfword lane.
    localparam int unsigned LANE_W = 8;
    localparam int unsigned HALF_W = 2 * LANE_W;
    // Width of the rotate selector (rotation in whole bytes, 0 to 3).
    localparam int unsigned ROT_W  = 2;

    // Operation codes. Bit 2 set selects the rotate-then-extend group.
    typedef enum logic [2:0] {
        OP_MIRROR     = 3'd0,
        OP_WORD_FLIP  = 3'd1,
        OP_HALF_SWAP  = 3'd2,
        OP_LOW_SWAP_S = 3'd3,
        OP_SEXT_BYTE  = 3'd4,
        OP_SEXT_HALF  = 3'd5,
        OP_ZEXT_BYTE  = 3'd6,
        OP_ZEXT_HALF  = 3'd7
    } reo_op_e;

    // Group selector: true for the extend group.
    function automatic logic is_extend(input reo_op_e op);
        return op[2];
    endfunction

endpackage

// File: rtl/reo_permute.sv
// Module: reo_permute
// Computes the four reorder-only transforms in parallel and picks one.
// Assumes DATA_W is a multiple of 16. Purely combinational; the rotate
// selector is not an input here, so it cannot affect these results.
module reo_permute
    import reo_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic [1:0]        kind,
    output logic [DATA_W-1:0] dst
);
    localparam int unsigned NLANES = DATA_W / LANE_W;
    localparam int unsigned NHALF  = DATA_W / HALF_W;

    logic [DATA_W-1:0] mirror_w;
    logic [DATA_W-1:0] flip_w;
    logic [DATA_W-1:0] hswap_w;
    logic [DATA_W-1:0] lswap_w;

    // Bit mirror: one wire per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
        assign mirror_w[i] = src[DATA_W-1-i];
    end

    // Whole-word lane reversal: lane b takes lane NLANES-1-b.
    for (genvar b = 0; b < NLANES; b++) begin : g_flip
        assign flip_w[b*LANE_W +: LANE_W] = src[(NLANES-1-b)*LANE_W +: LANE_W];
    end

    // Swap the two lanes inside each halfword independently.
    for (genvar h = 0; h < NHALF; h++) begin : g_hswap
        assign hswap_w[h*HALF_W          +: LANE_W] = src[h*HALF_W + LANE_W +: LANE_W];
        assign hswap_w[h*HALF_W + LANE_W +: LANE_W] = src[h*HALF_W          +: LANE_W];
    end

    // Low halfword swap, upper part filled with the new bit 15 (source bit 7).
    assign lswap_w[HALF_W-1:0]      = {src[LANE_W-1:0], src[HALF_W-1:LANE_W]};
    assign lswap_w[DATA_W-1:HALF_W] = {(DATA_W-HALF_W){src[LANE_W-1]}};

    // Select the requested reorder result.
    always_comb begin
        unique case (kind)
            2'd0:    dst = mirror_w;
            2'd1:    dst = flip_w;
            2'd2:    dst = hswap_w;
            default: dst = lswap_w;
        endcase
    end

endmodule

// File: rtl/reo_rotator.sv
// Module: reo_rotator
// Rotates the source right by a whole number of byte lanes (0 to 3).
// Assumes DATA_W holds at least 4 lanes. Purely combinational.
module reo_rotator
    import reo_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic [ROT_W-1:0]  amount,
    output logic [DATA_W-1:0] dst
);
    localparam int unsigned NROT = 1 << ROT_W;

    logic [DATA_W-1:0] cand [NROT];

    // One fixed rotation per selector value; amount 0 passes through.
    for (genvar r = 0; r < NROT; r++) begin : g_rot
        if (r == 0) begin : g_none
            assign cand[r] = src;
        end else begin : g_some
            assign cand[r] = {src[r*LANE_W-1:0], src[DATA_W-1:r*LANE_W]};
        end
    end

    // Pick the rotation given by the selector.
    always_comb begin
        dst = cand[amount];
    end

endmodule

// File: rtl/reo_extender.sv
// Module: reo_extender
// Widens the low byte or low halfword of its input to DATA_W bits, either
// replicating the top bit of the field or filling with zeros.
// Assumes DATA_W > HALF_W. Purely combinational.
module reo_extender
    import reo_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic              use_half,
    input  logic              zero_fill,
    output logic [DATA_W-1:0] dst
);
    logic              fill_b;
    logic              fill_h;
    logic [DATA_W-1:0] wide_b;
    logic [DATA_W-1:0] wide_h;

    // Fill bits: the field's top bit, or zero when zero-extending.
    assign fill_b = zero_fill ? 1'b0 : src[LANE_W-1];
    assign fill_h = zero_fill ? 1'b0 : src[HALF_W-1];

    assign wide_b = {{(DATA_W-LANE_W){fill_b}}, src[LANE_W-1:0]};
    assign wide_h = {{(DATA_W-HALF_W){fill_h}}, src[HALF_W-1:0]};

    // Choose the field width.
    always_comb begin
        dst = use_half ? wide_h : wide_b;
    end

endmodule

// File: rtl/reorder_ext_unit.sv
// Module: reorder_ext_unit (top)
// Single-step word reorder and extend unit. Codes 0..3 reorder the input
// without rotation; codes 4..7 rotate right by 8*rot_sel, then extend.
// Assumes a 32-bit word by default. No clock, reset or state.
module reorder_ext_unit
    import reo_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [2:0]        op_sel,
    input  logic [ROT_W-1:0]  rot_sel,
    output logic [DATA_W-1:0] data_out
);
    reo_op_e           op;
    logic [DATA_W-1:0] perm_q;
    logic [DATA_W-1:0] rot_q;
    logic [DATA_W-1:0] ext_q;

    assign op = reo_op_e'(op_sel);

    reo_permute #(.DATA_W(DATA_W)) u_permute (
        .src  (data_in),
        .kind (op_sel[1:0]),
        .dst  (perm_q)
    );

    reo_rotator #(.DATA_W(DATA_W)) u_rotator (
        .src    (data_in),
        .amount (rot_sel),
        .dst    (rot_q)
    );

    // Code bit 0 picks halfword width, code bit 1 picks zero fill.
    reo_extender #(.DATA_W(DATA_W)) u_extender (
        .src       (rot_q),
        .use_half  (op_sel[0]),
        .zero_fill (op_sel[1]),
        .dst       (ext_q)
    );

    // Route the result of the selected group to the output.
    always_comb begin
        data_out = is_extend(op) ? ext_q : perm_q;
    end

endmodule

// File: rtl/reorder_ext_unit_chk.sv
// Module: reorder_ext_unit_chk
// Port-level checks for reorder_ext_unit, bound to every instance.
// Assumes known inputs; skips evaluation while any input bit is unknown.
module reorder_ext_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic [DATA_W-1:0] data_in,
    input logic [2:0]        op_sel,
    input logic [1:0]        rot_sel,
    input logic [DATA_W-1:0] data_out
);
    // Evaluate output relations whenever any port changes.
    always_comb begin
        if (!$isunknown({data_in, op_sel, rot_sel})) begin
            if (op_sel == 3'd0) begin
                assert_mirror_ends_R1: assert (data_out[0] == data_in[DATA_W-1]
                                             && data_out[DATA_W-1] == data_in[0]);
            end
            if (op_sel == 3'd1) begin
                assert_flip_low_lane_R2: assert (data_out[7:0] == data_in[DATA_W-1 -: 8]);
            end
            if (op_sel == 3'd2) begin
                assert_half_swap_low_R3: assert (data_out[15:8] == data_in[7:0]);
            end
            if (op_sel == 3'd3) begin
                assert_low_swap_fill_R4: assert ($countones(data_out[DATA_W-1:16]) ==
                                                 (data_in[7] ? DATA_W-16 : 0));
            end
            if (op_sel == 3'd4) begin
                assert_sext_byte_fill_R6: assert ($countones(data_out[DATA_W-1:7]) == 0
                                              || $countones(data_out[DATA_W-1:7]) == DATA_W-7);
            end
            if (op_sel == 3'd5) begin
                assert_sext_half_fill_R7: assert ($countones(data_out[DATA_W-1:15]) == 0
                                              || $countones(data_out[DATA_W-1:15]) == DATA_W-15);
            end
            if (op_sel == 3'd6) begin
                assert_zext_byte_top_R8: assert (data_out[DATA_W-1:8] == '0);
            end
            if (op_sel == 3'd7) begin
                assert_zext_half_top_R9: assert (data_out[DATA_W-1:16] == '0);
            end
            if (op_sel[2] && rot_sel == 2'd0 && op_sel[0]) begin
                assert_no_rot_half_R5: assert (data_out[15:0] == data_in[15:0]);
            end
            if (data_in == '0) begin
                assert_zero_in_zero_out_R11: assert (data_out == '0);
            end
        end
    end

endmodule

bind reorder_ext_unit reorder_ext_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .data_in  (data_in),
    .op_sel   (op_sel),
    .rot_sel  (rot_sel),
    .data_out (data_out)
);

// File: tb/reorder_ext_unit_tb_top.sv
// Bench for reorder_ext_unit: directed vectors plus seeded random words over
// every operation code and rotate value, compared with a bench model.
module reorder_ext_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] data_in;
    logic [2:0]  op_sel;
    logic [1:0]  rot_sel;
    logic [31:0] data_out;

    int n_vec;
    int n_bad;
    bit done;

    reorder_ext_unit dut_i (
        .data_in  (data_in),
        .op_sel   (op_sel),
        .rot_sel  (rot_sel),
        .data_out (data_out)
    );

    // 50 MHz clock paces the stimulus.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Bench model written from the requirements.
    function automatic logic [31:0] expect_of(input logic [31:0] d,
                                              input logic [2:0] op,
                                              input logic [1:0] rot);
        logic [63:0] dd;
        logic [31:0] r;
        logic [31:0] m;
        dd = {d, d} >> (8 * rot);
        r  = dd[31:0];
        m  = '0;
        case (op)
            3'd0: for (int i = 0; i < 32; i++) m[i] = d[31-i];
            3'd1: m = {d[7:0], d[15:8], d[23:16], d[31:24]};
            3'd2: m = {d[23:16], d[31:24], d[7:0], d[15:8]};
            3'd3: m = {{16{d[7]}}, d[7:0], d[15:8]};
            3'd4: m = {{24{r[7]}}, r[7:0]};
            3'd5: m = {{16{r[15]}}, r[15:0]};
            3'd6: m = {24'd0, r[7:0]};
            default: m = {16'd0, r[15:0]};
        endcase
        return m;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Drive one vector after a falling edge, sample mid low phase, compare.
    task automatic apply(input logic [31:0] d, input logic [2:0] op,
                         input logic [1:0] rot, input logic [31:0] exp_v,
                         input string req);
        @(negedge clk);
        data_in = d;
        op_sel  = op;
        rot_sel = rot;
        #5;
        n_vec++;
        if (data_out !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d rot=%0d in=%h actual=%h expected=%h",
                     req, op, rot, d, data_out, exp_v);
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [31:0] base;
        n_vec   = 0;
        n_bad   = 0;
        done    = 1'b0;
        rst_n   = 1'b0;
        data_in = '0;
        op_sel  = '0;
        rot_sel = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R11: all-zero input gives zero under every code.
        for (int op = 0; op < 8; op++)
            apply(32'h0, 3'(op), 2'd0, 32'h0, "R11");

        // Directed known vectors.
        apply(32'h12345678, 3'd0, 2'd0, 32'h1E6A2C48, "R1");
        apply(32'h12345678, 3'd1, 2'd0, 32'h78563412, "R2");
        apply(32'h12345678, 3'd2, 2'd0, 32'h34127856, "R3");
        apply(32'h33448899, 3'd3, 2'd0, 32'hFFFF9988, "R4");
        apply(32'h55AA8765, 3'd4, 2'd0, 32'h00000065, "R6");
        apply(32'h55AA8765, 3'd5, 2'd0, 32'hFFFF8765, "R7");
        apply(32'h55AA8765, 3'd6, 2'd0, 32'h00000065, "R8");
        apply(32'h55AA8765, 3'd7, 2'd0, 32'h00008765, "R9");
        // R5: rotated extraction.
        apply(32'h55AA8765, 3'd4, 2'd1, 32'hFFFFFF87, "R5");
        apply(32'h55AA8765, 3'd5, 2'd2, 32'h000055AA, "R5");
        apply(32'h55AA8765, 3'd4, 2'd2, 32'hFFFFFFAA, "R5");
        apply(32'h55AA8765, 3'd6, 2'd3, 32'h00000055, "R5");
        apply(32'h55AA8765, 3'd7, 2'd3, 32'h00006555, "R5");
        apply(32'h55AA8765, 3'd7, 2'd1, 32'h0000AA87, "R5");
        // Corner words: all ones, single top bit, single low bit.
        apply(32'hFFFFFFFF, 3'd6, 2'd2, 32'h000000FF, "R8");
        apply(32'h80000000, 3'd0, 2'd0, 32'h00000001, "R1");
        apply(32'h00000080, 3'd3, 2'd0, 32'hFFFF8000, "R4");
        apply(32'h00008000, 3'd5, 2'd0, 32'hFFFF8000, "R7");
        apply(32'h00000080, 3'd4, 2'd0, 32'hFFFFFF80, "R6");

        // R10: reorder codes give the same output for every rotate value.
        for (int op = 0; op < 4; op++) begin
            base = expect_of(32'hA1B2C3D4, 3'(op), 2'd0);
            for (int r = 0; r < 4; r++)
                apply(32'hA1B2C3D4, 3'(op), 2'(r), base, "R10");
        end

        // Seeded random words over every code and rotate value.
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            w = $urandom();
            for (int op = 0; op < 8; op++)
                for (int r = 0; r < 4; r++)
                    apply(w, 3'(op), 2'(r), expect_of(w, 3'(op), 2'(r)),
                          (op < 4 && r != 0) ? "R10" :
                          (op >= 4 && r != 0) ? "R5" : req_of(3'(op)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule